// File: doc/BRIEF.md
# Pointer-Selected Scratch Register File

This block holds sixteen 16-bit working registers that are never addressed directly. Three 4-bit pointer registers (named N, P and X) each hold a register number, and a 2-bit choice input decides which pointer names the active entry in a given cycle. The active entry is always visible as a 16-bit address output. One of its two bytes is always visible on an 8-bit bus output.

In each clock cycle one operation may be applied to the active entry. The entry can count up by one, count down by one, or take a new low or high byte from the 8-bit bus input. In the same cycle, any of the three pointers may take a new register number through its own load enable.

The pointer update and the entry operation share a clock edge. The operation always acts on the entry that the pointer selected before that edge. Decoding of instructions is left to the surrounding logic, which drives the operation code directly.

Top module: `spad_file`

## Requirements
- R1: An active-low reset clears all sixteen registers and all three pointers to zero, so the address output reads 0x0000 during reset and after it, whatever pointer is chosen.
- R2: The choice input selects the pointer that names the active entry: code 0 selects N, 1 selects P, 2 selects X, and 3 also selects N.
- R3: Bits 0, 1 and 2 of the pointer-load input enable loading N, P and X respectively from the new-pointer input at the clock edge. A same-cycle operation acts on the entry named by the pointer's value before that edge, and the address output shows the newly named entry afterwards.
- R4: The bus output carries bits 7:0 of the active entry when the byte select is 0 and bits 15:8 when it is 1, with no clock delay.
- R5: Operation code 1 adds one to the active entry, and 0xFFFF wraps to 0x0000.
- R6: Operation code 2 subtracts one from the active entry, and 0x0000 wraps to 0xFFFF.
- R7: Operation code 3 writes the bus input into bits 7:0 of the active entry and leaves bits 15:8 unchanged.
- R8: Operation code 4 writes the bus input into bits 15:8 of the active entry and leaves bits 7:0 unchanged.
- R9: Operation code 0 and the unused codes 5 to 7 change no register. Reading an entry onto the address or bus outputs never changes it, and an operation changes only the active entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Operation on the active entry: 0 none, 1 increment, 2 decrement, 3 load low byte, 4 load high byte |
| selChoice | input | 2 | Pointer choice: 0 N, 1 P, 2 X, 3 N |
| selLoad | input | 3 | Pointer load enables: bit 0 N, bit 1 P, bit 2 X |
| selNew | input | 4 | New register number for the enabled pointers |
| busIn | input | 8 | Byte written by the byte-load operations |
| byteSel | input | 1 | Bus output byte: 0 low, 1 high |
| addrOut | output | 16 | Contents of the active entry |
| busOut | output | 8 | Selected byte of the active entry |

## Verification
The bench makes both counters cross their wrap points. A design that saturated, or that carried into a wider value, would then show 0xFFFF or 0x0000 in the wrong place. It loads a pointer and operates in the same cycle. If the pointer update were applied before the operation, the operation would land on the newly named register, and a later read of the old register would differ. It also reads back registers untouched by recent operations, and it applies the unused operation codes. Those steps expose writes that leak to the wrong entry and reserved codes that alter state.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_LDLO = 3'd3,
    OP_LDHI = 3'd4
  } spadOp_e;

  typedef enum logic [1:0] {
    PICK_N = 2'd0,
    PICK_P = 2'd1,
    PICK_X = 2'd2
  } spadPick_e;

  localparam int PTR_CNT = 3;

  typedef struct packed {
    logic                incEn;
    logic                decEn;
    logic                loLdEn;
    logic                hiLdEn;
    spadPick_e           pick;
    logic [PTR_CNT-1:0]  ptrLd;
  } spadStrb_t;
endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic [2:0]         opCode,
  input  logic [1:0]         selChoice,
  input  logic [PTR_CNT-1:0] selLoad,
  output spadStrb_t          strb
);
  always_comb begin
    strb        = '0;
    strb.incEn  = (opCode == OP_INC);
    strb.decEn  = (opCode == OP_DEC);
    strb.loLdEn = (opCode == OP_LDLO);
    strb.hiLdEn = (opCode == OP_LDHI);
    strb.ptrLd  = selLoad;
    case (selChoice)
      2'd1:    strb.pick = PICK_P;
      2'd2:    strb.pick = PICK_X;
      default: strb.pick = PICK_N;
    endcase
  end
endmodule

// File: rtl/spad_dp.sv
module spad_dp
  import spad_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int REG_CNT = 16,
  parameter int BYTE_W  = 8,
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int HI_W   = REG_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  spadStrb_t         strb,
  input  logic [IDX_W-1:0]  selNew,
  input  logic [BYTE_W-1:0] busIn,
  input  logic              byteSel,
  output logic [REG_W-1:0]  addrOut,
  output logic [BYTE_W-1:0] busOut
);
  logic [IDX_W-1:0] ptrQ [PTR_CNT];
  logic [REG_W-1:0] regQ [REG_CNT];
  logic [IDX_W-1:0] curIdx;
  logic [REG_W-1:0] curVal;
  logic [REG_W-1:0] nextVal;
  logic             anyWr;

  for (genvar p = 0; p < PTR_CNT; p++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              ptrQ[p] <= '0;
      else if (strb.ptrLd[p]) ptrQ[p] <= selNew;
    end
  end

  always_comb begin
    case (strb.pick)
      PICK_P:  curIdx = ptrQ[1];
      PICK_X:  curIdx = ptrQ[2];
      default: curIdx = ptrQ[0];
    endcase
  end

  assign curVal = regQ[curIdx];
  assign anyWr  = strb.incEn | strb.decEn | strb.loLdEn | strb.hiLdEn;

  always_comb begin
    nextVal = curVal;
    if (strb.incEn)       nextVal = curVal + REG_W'(1);
    else if (strb.decEn)  nextVal = curVal - REG_W'(1);
    else if (strb.loLdEn) nextVal = {curVal[REG_W-1:BYTE_W], busIn};
    else if (strb.hiLdEn) nextVal = {busIn[HI_W-1:0], curVal[BYTE_W-1:0]};
  end

  for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          regQ[r] <= '0;
      else if (anyWr && curIdx == IDX_W'(r)) regQ[r] <= nextVal;
    end
  end

  assign addrOut = curVal;
  assign busOut  = byteSel ? BYTE_W'(curVal[REG_W-1:BYTE_W]) : curVal[BYTE_W-1:0];
endmodule

// File: rtl/spad_file.sv
module spad_file
  import spad_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opCode,
  input  logic [1:0]       selChoice,
  input  logic [2:0]       selLoad,
  input  logic [IDX_W-1:0] selNew,
  input  logic [7:0]       busIn,
  input  logic             byteSel,
  output logic [REG_W-1:0] addrOut,
  output logic [7:0]       busOut
);
  spadStrb_t strb;

  spad_ctrl u_ctrl (
    .opCode   (opCode),
    .selChoice(selChoice),
    .selLoad  (selLoad),
    .strb     (strb)
  );

  spad_dp #(.REG_W(REG_W), .REG_CNT(REG_CNT), .BYTE_W(8)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .selNew (selNew),
    .busIn  (busIn),
    .byteSel(byteSel),
    .addrOut(addrOut),
    .busOut (busOut)
  );
endmodule

// File: rtl/spad_chk.sv
module spad_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       opCode,
  input logic [1:0]       selChoice,
  input logic [2:0]       selLoad,
  input logic [7:0]       busIn,
  input logic             byteSel,
  input logic [REG_W-1:0] addrOut,
  input logic [7:0]       busOut
);
  // R4
  bus_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOut == (byteSel ? addrOut[15:8] : addrOut[7:0]));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd1 && selLoad == 3'd0) ##1 (selChoice == $past(selChoice))
    |-> addrOut == $past(addrOut) + 16'd1);

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2 && selLoad == 3'd0) ##1 (selChoice == $past(selChoice))
    |-> addrOut == $past(addrOut) - 16'd1);

  // R7
  lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd3 && selLoad == 3'd0) ##1 (selChoice == $past(selChoice))
    |-> addrOut == {$past(addrOut[15:8]), $past(busIn)});

  // R8
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd4 && selLoad == 3'd0) ##1 (selChoice == $past(selChoice))
    |-> addrOut == {$past(busIn), $past(addrOut[7:0])});

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opCode == 3'd0 || opCode > 3'd4) && selLoad == 3'd0)
    ##1 (selChoice == $past(selChoice))
    |-> $stable(addrOut));
endmodule

bind spad_file spad_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/spad_file_bench.sv
module spad_file_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ch;
    logic [2:0]  ld;
    logic [3:0]  nv;
    logic [7:0]  din;
    logic        bs;
    logic [15:0] expA;
    logic [7:0]  expB;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 2'd0, 3'd0, 4'd0, 8'h00, 1'b0, 16'h0000, 8'h00, 4'd1}, // R1 idle after reset
    '{3'd2, 2'd0, 3'd0, 4'd0, 8'h00, 1'b0, 16'hFFFF, 8'hFF, 4'd6}, // R6 wrap down
    '{3'd1, 2'd0, 3'd0, 4'd0, 8'h00, 1'b0, 16'h0000, 8'h00, 4'd5}, // R5 wrap up
    '{3'd3, 2'd0, 3'd1, 4'd3, 8'h5A, 1'b0, 16'h0000, 8'h00, 4'd3}, // R3 op on old N
    '{3'd0, 2'd1, 3'd0, 4'd0, 8'h00, 1'b0, 16'h005A, 8'h5A, 4'd2}, // R2 pick P
    '{3'd4, 2'd1, 3'd0, 4'd0, 8'hC3, 1'b1, 16'hC35A, 8'hC3, 4'd8}, // R8
    '{3'd3, 2'd0, 3'd0, 4'd0, 8'h11, 1'b0, 16'h0011, 8'h11, 4'd7}, // R7
    '{3'd0, 2'd1, 3'd2, 4'd5, 8'h00, 1'b0, 16'h0000, 8'h00, 4'd3}, // R3 load P
    '{3'd1, 2'd2, 3'd4, 4'd3, 8'h00, 1'b1, 16'h0011, 8'h00, 4'd3}, // R3 op on old X
    '{3'd2, 2'd2, 3'd0, 4'd0, 8'h00, 1'b0, 16'h0010, 8'h10, 4'd6}, // R6
    '{3'd5, 2'd2, 3'd0, 4'd0, 8'hFF, 1'b0, 16'h0010, 8'h10, 4'd9}, // R9 reserved code
    '{3'd7, 2'd3, 3'd0, 4'd0, 8'hFF, 1'b0, 16'h0010, 8'h10, 4'd2}, // R2 code 3 is N
    '{3'd4, 2'd1, 3'd0, 4'd0, 8'h80, 1'b1, 16'h8000, 8'h80, 4'd8}, // R8 on P
    '{3'd0, 2'd0, 3'd0, 4'd0, 8'h00, 1'b0, 16'h0010, 8'h10, 4'd9}, // R9 other entry kept
    '{3'd0, 2'd0, 3'd1, 4'd0, 8'h00, 1'b1, 16'hC35B, 8'hC3, 4'd2}, // R2 N to 0
    '{3'd1, 2'd2, 3'd7, 4'd9, 8'h00, 1'b0, 16'h0000, 8'h00, 4'd3}  // R3 all pointers
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  selChoice = '0;
  logic [2:0]  selLoad = '0;
  logic [3:0]  selNew = '0;
  logic [7:0]  busIn = '0;
  logic        byteSel = 1'b0;
  logic [15:0] addrOut;
  logic [7:0]  busOut;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spad_file u_spad_file (
    .clk(clk), .rstN(rstN), .opCode(opCode), .selChoice(selChoice),
    .selLoad(selLoad), .selNew(selNew), .busIn(busIn), .byteSel(byteSel),
    .addrOut(addrOut), .busOut(busOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [1:0] ch, input logic [2:0] ld,
                      input logic [3:0] nv, input logic [7:0] din, input logic bs);
    @(negedge clk);
    opCode = op; selChoice = ch; selLoad = ld; selNew = nv; busIn = din; byteSel = bs;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", addrOut, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].op, VECS[i].ch, VECS[i].ld, VECS[i].nv, VECS[i].din, VECS[i].bs);
      check($sformatf("R%0d addr vec%0d", VECS[i].req, i), addrOut, VECS[i].expA);
      check($sformatf("R4 bus vec%0d", i), {8'h00, busOut}, {8'h00, VECS[i].expB});
    end

    // All pointers now name entry 9, which holds 0x0000
    step(3'd2, 2'd0, 3'd0, 4'd0, 8'h00, 1'b0);
    check("R6 wrap from zero", addrOut, 16'hFFFF);
    step(3'd1, 2'd1, 3'd0, 4'd0, 8'h00, 1'b0);
    check("R5 wrap to zero", addrOut, 16'h0000);
    step(3'd4, 2'd2, 3'd0, 4'd0, 8'hFF, 1'b0);
    step(3'd3, 2'd2, 3'd0, 4'd0, 8'hFF, 1'b0);
    check("R7 R8 build 0xFFFF", addrOut, 16'hFFFF);
    step(3'd1, 2'd2, 3'd0, 4'd0, 8'h00, 1'b0);
    check("R5 all-ones increment", addrOut, 16'h0000);
    step(3'd4, 2'd0, 3'd0, 4'd0, 8'h12, 1'b1);
    check("R4 high byte", {8'h00, busOut}, 16'h0012);
    @(negedge clk);
    opCode = 3'd0; byteSel = 1'b0;
    #1;
    check("R4 low byte", {8'h00, busOut}, 16'h0000);

    // Reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async clear", addrOut, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    step(3'd0, 2'd2, 3'd0, 4'd0, 8'h00, 1'b0);
    check("R1 entry 0 cleared", addrOut, 16'h0000);
    step(3'd0, 2'd0, 3'd1, 4'd3, 8'h00, 1'b0);
    check("R1 entry 3 cleared", addrOut, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule